// File: doc/BRIEF.md
# Flushable Word FIFO Pair

This block holds two queues of 32-bit words that sit between a register port and the byte engine of a packet-mode serial bus controller. Software writes outgoing words into the transmit queue and the engine pops them. The engine pushes incoming words into the receive queue and software reads them out. Each word carries four payload bytes. A control register holds a trigger level for each queue and a flush bit for each queue. A flush bit stays set until the hardware has emptied that queue, so software can poll it.

A status register reports the free slots in the transmit queue and the filled words in the receive queue. Two level outputs ask for service: one asks for the transmit queue to be refilled and one asks for the receive queue to be drained. Two one-cycle event pulses report a rejected write to a full transmit queue and a rejected read from an empty receive queue. An interrupt block outside this one masks and latches these signals.

The reset input is asserted asynchronously. Its release passes through two flops before the block leaves reset.

Top module: `word_fifo_pair`

## Requirements
- R1: After reset both queues are empty. The status register reads 0x80, the control register reads 0 and both event pulses are low. The transmit request is high because 8 free slots exceed the reset trigger of 0, and the receive request is low.
- R2: Register addresses are 0 = control, 1 = status, 2 = transmit data (write only, reads 0), 3 = receive data. Control bits 7:5 hold the transmit trigger, 4:2 the receive trigger, bit 1 the transmit flush and bit 0 the receive flush. All unused bits read 0.
- R3: Words written to address 2 appear on `eng_tx_word` in write order. `eng_tx_valid` is high while the transmit queue is not empty. `eng_tx_pop` removes the head word, and a pop on an empty queue is ignored.
- R4: `eng_rx_push` stores `eng_rx_word` while `eng_rx_ready` (queue not full) is high, and a push into a full queue is discarded. A read of address 3 returns the head word and removes it, in push order.
- R5: Each queue holds 8 words. The status register carries transmit free slots in bits 7:4 and receive fill in bits 3:0. A push and a pop on the same queue in the same cycle both take effect.
- R6: A write to address 2 while the transmit queue holds 8 words discards the word and leaves the queue unchanged, except for a same-cycle engine pop. `tx_ovf` is then high for exactly the following cycle.
- R7: A read of address 3 while the receive queue is empty returns 0 and changes no state. `rx_unf` is then high for exactly the following cycle.
- R8: Writing 1 to a flush bit makes it read 1 in the next cycle. The following edge empties that queue and clears the bit. The flush wins over any push or pop made in that pending cycle. The other queue is untouched, and writing 0 to a flush bit has no effect.
- R9: `tx_req` is high exactly while the transmit free-slot count is greater than the transmit trigger.
- R10: `rx_req` is high exactly while the receive fill count is greater than the receive trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at address 3) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the address |
| eng_tx_pop | input | 1 | Engine takes the transmit head word |
| eng_tx_word | output | 32 | Transmit head word |
| eng_tx_valid | output | 1 | Transmit queue not empty |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_word | input | 32 | Received word |
| eng_rx_ready | output | 1 | Receive queue not full |
| tx_req | output | 1 | Transmit refill request level |
| rx_req | output | 1 | Receive drain request level |
| tx_ovf | output | 1 | Transmit overflow pulse |
| rx_unf | output | 1 | Receive underflow pulse |

## Verification
Assertions check on every cycle that the fill counts stay within the depth and that a rejected push or pop leaves the count alone. They also check that a pending flush empties its queue on the next edge and clears itself, and that each overflow or underflow pulse follows a cycle in which its queue was full or empty. Word order through both queues, the exact readback of the control and status layouts, trigger comparisons at the threshold values and the precedence of a flush over a same-cycle push can only be shown by the bench's scenarios. The bench compares these against its queue model on each clock.

// File: rtl/wfp_pkg.sv
package wfp_pkg;
  localparam int WORD_W      = 32;
  localparam int FIFO_DEPTH  = 8;
  localparam int TRIG_W      = 3;
  localparam int RXFL_BIT    = 0;
  localparam int TXFL_BIT    = 1;
  localparam int RXTRIG_LSB  = 2;
  localparam int TXTRIG_LSB  = 5;
  localparam int STAT_FLD_W  = 4;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_STAT = 2'd1,
    RA_TXD  = 2'd2,
    RA_RXD  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/wfp_rst_sync.sv
module wfp_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;
endmodule

// File: rtl/wfp_fifo.sv
module wfp_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    ptr_inc = (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign count = cnt_q;
  assign head  = mem[rd_ptr_q];

  // flush overrides any transfer in the same cycle
  assign push_ok = push && !full  && !flush;
  assign pop_ok  = pop  && !empty && !flush;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push_ok) wr_ptr_d = ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_d = ptr_inc(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // storage carries no reset; written only under its enable
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= push_data;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R5

  AST_FULL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (count == $past(count))); // R6

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !flush) |=> empty); // R3
endmodule

// File: rtl/wfp_ctrl.sv
module wfp_ctrl
  import wfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  output logic              tx_flush,
  output logic              rx_flush,
  output logic [TRIG_W-1:0] tx_trig,
  output logic [TRIG_W-1:0] rx_trig
);
  logic              tx_fl_q, tx_fl_d;
  logic              rx_fl_q, rx_fl_d;
  logic [TRIG_W-1:0] tx_trig_q, tx_trig_d;
  logic [TRIG_W-1:0] rx_trig_q, rx_trig_d;

  always_comb begin
    // flush bits live for one cycle unless written again
    tx_fl_d   = wr_en && wdata[TXFL_BIT];
    rx_fl_d   = wr_en && wdata[RXFL_BIT];
    tx_trig_d = tx_trig_q;
    rx_trig_d = rx_trig_q;
    if (wr_en) begin
      tx_trig_d = wdata[TXTRIG_LSB +: TRIG_W];
      rx_trig_d = wdata[RXTRIG_LSB +: TRIG_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_fl_q   <= 1'b0;
      rx_fl_q   <= 1'b0;
      tx_trig_q <= '0;
      rx_trig_q <= '0;
    end else begin
      tx_fl_q   <= tx_fl_d;
      rx_fl_q   <= rx_fl_d;
      tx_trig_q <= tx_trig_d;
      rx_trig_q <= rx_trig_d;
    end
  end

  assign tx_flush = tx_fl_q;
  assign rx_flush = rx_fl_q;
  assign tx_trig  = tx_trig_q;
  assign rx_trig  = rx_trig_q;

  AST_TXFL_SELF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flush && !(wr_en && wdata[TXFL_BIT])) |=> !tx_flush); // R8

  AST_RXFL_SELF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flush && !(wr_en && wdata[RXFL_BIT])) |=> !rx_flush); // R8
endmodule

// File: rtl/wfp_evt.sv
module wfp_evt #(
  parameter int CW     = 4,
  parameter int TRIG_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     tx_free,
  input  logic [CW-1:0]     rx_cnt,
  input  logic [TRIG_W-1:0] tx_trig,
  input  logic [TRIG_W-1:0] rx_trig,
  input  logic              ovf_hit,
  input  logic              unf_hit,
  output logic              tx_req,
  output logic              rx_req,
  output logic              tx_ovf,
  output logic              rx_unf
);
  localparam int MW = (CW > TRIG_W) ? CW : TRIG_W;

  logic ovf_q, ovf_d;
  logic unf_q, unf_d;

  assign tx_req = MW'(tx_free) > MW'(tx_trig);
  assign rx_req = MW'(rx_cnt)  > MW'(rx_trig);

  always_comb begin
    ovf_d = ovf_hit;
    unf_d = unf_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assign tx_ovf = ovf_q;
  assign rx_unf = unf_q;
endmodule

// File: rtl/word_fifo_pair.sv
module word_fifo_pair
  import wfp_pkg::*;
#(
  parameter int WW    = WORD_W,
  parameter int DEPTH = FIFO_DEPTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [WW-1:0] reg_wdata,
  output logic [WW-1:0] reg_rdata,
  input  logic          eng_tx_pop,
  output logic [WW-1:0] eng_tx_word,
  output logic          eng_tx_valid,
  input  logic          eng_rx_push,
  input  logic [WW-1:0] eng_rx_word,
  output logic          eng_rx_ready,
  output logic          tx_req,
  output logic          rx_req,
  output logic          tx_ovf,
  output logic          rx_unf
);
  localparam int CW = $clog2(DEPTH + 1);

  logic              srst_n;
  logic              ctrl_wr, tx_push, rx_pop;
  logic              tx_flush, rx_flush;
  logic [TRIG_W-1:0] tx_trig, rx_trig;
  logic [CW-1:0]     tx_cnt, rx_cnt, tx_free;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [WW-1:0]     rx_head;
  logic              ovf_hit, unf_hit;

  wfp_rst_sync u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (srst_n)
  );

  assign ctrl_wr = reg_wr && (reg_addr == RA_CTRL);
  assign tx_push = reg_wr && (reg_addr == RA_TXD);
  assign rx_pop  = reg_rd && (reg_addr == RA_RXD);

  wfp_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (srst_n),
    .wr_en    (ctrl_wr),
    .wdata    (reg_wdata[7:0]),
    .tx_flush (tx_flush),
    .rx_flush (rx_flush),
    .tx_trig  (tx_trig),
    .rx_trig  (rx_trig)
  );

  wfp_fifo #(.WIDTH(WW), .DEPTH(DEPTH), .CW(CW)) u_txq (
    .clk       (clk),
    .rst_n     (srst_n),
    .flush     (tx_flush),
    .push      (tx_push),
    .push_data (reg_wdata),
    .pop       (eng_tx_pop),
    .head      (eng_tx_word),
    .count     (tx_cnt),
    .full      (tx_full),
    .empty     (tx_empty)
  );

  wfp_fifo #(.WIDTH(WW), .DEPTH(DEPTH), .CW(CW)) u_rxq (
    .clk       (clk),
    .rst_n     (srst_n),
    .flush     (rx_flush),
    .push      (eng_rx_push),
    .push_data (eng_rx_word),
    .pop       (rx_pop),
    .head      (rx_head),
    .count     (rx_cnt),
    .full      (rx_full),
    .empty     (rx_empty)
  );

  assign eng_tx_valid = !tx_empty;
  assign eng_rx_ready = !rx_full;
  assign tx_free      = CW'(DEPTH) - tx_cnt;
  assign ovf_hit      = tx_push && tx_full;
  assign unf_hit      = rx_pop && rx_empty;

  wfp_evt #(.CW(CW), .TRIG_W(TRIG_W)) u_evt (
    .clk     (clk),
    .rst_n   (srst_n),
    .tx_free (tx_free),
    .rx_cnt  (rx_cnt),
    .tx_trig (tx_trig),
    .rx_trig (rx_trig),
    .ovf_hit (ovf_hit),
    .unf_hit (unf_hit),
    .tx_req  (tx_req),
    .rx_req  (rx_req),
    .tx_ovf  (tx_ovf),
    .rx_unf  (rx_unf)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: reg_rdata[7:0] = {tx_trig, rx_trig, tx_flush, rx_flush};
      RA_STAT: reg_rdata[7:0] = {STAT_FLD_W'(tx_free), STAT_FLD_W'(rx_cnt)};
      RA_RXD:  reg_rdata      = rx_empty ? '0 : rx_head;
      default: reg_rdata      = '0;
    endcase
  end

  AST_TX_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!srst_n)
    tx_flush |=> tx_empty); // R8

  AST_RX_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!srst_n)
    rx_flush |=> rx_empty); // R8

  AST_OVF_AFTER_FULL: assert property (@(posedge clk) disable iff (!srst_n)
    tx_ovf |-> $past(tx_full)); // R6

  AST_UNF_AFTER_EMPTY: assert property (@(posedge clk) disable iff (!srst_n)
    rx_unf |-> $past(rx_empty)); // R7
endmodule

// File: tb/sim_word_fifo_pair.sv
module sim_word_fifo_pair;
  localparam int D = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd, eng_tx_pop, eng_rx_push;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, eng_rx_word;
  logic [31:0] reg_rdata, eng_tx_word;
  logic        eng_tx_valid, eng_rx_ready, tx_req, rx_req, tx_ovf, rx_unf;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model state
  logic [31:0] txq[$];
  logic [31:0] rxq[$];
  int  ttrig = 0, rtrig = 0;
  bit  tfl = 0, rfl = 0, eovf = 0, eunf = 0;

  always #10 clk = ~clk;

  word_fifo_pair u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_tx_pop(eng_tx_pop), .eng_tx_word(eng_tx_word),
    .eng_tx_valid(eng_tx_valid), .eng_rx_push(eng_rx_push),
    .eng_rx_word(eng_rx_word), .eng_rx_ready(eng_rx_ready),
    .tx_req(tx_req), .rx_req(rx_req), .tx_ovf(tx_ovf), .rx_unf(rx_unf)
  );

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(input logic [1:0] a, input string tag);
    logic [31:0] er;
    int tfree;
    tfree = D - txq.size();
    case (a)
      2'd0: er = {24'd0, 3'(ttrig), 3'(rtrig), tfl, rfl};
      2'd1: er = {24'd0, 4'(tfree), 4'(rxq.size())};
      2'd3: er = (rxq.size() > 0) ? rxq[0] : 32'd0;
      default: er = 32'd0;
    endcase
    chk(tag, reg_rdata, er);
    chk("R9", {31'd0, tx_req}, {31'd0, tfree > ttrig});
    chk("R10", {31'd0, rx_req}, {31'd0, rxq.size() > rtrig});
    chk("R6", {31'd0, tx_ovf}, {31'd0, eovf});
    chk("R7", {31'd0, rx_unf}, {31'd0, eunf});
    chk("R3", {31'd0, eng_tx_valid}, {31'd0, txq.size() > 0});
    chk("R4", {31'd0, eng_rx_ready}, {31'd0, rxq.size() < D});
    if (txq.size() > 0) chk("R3", eng_tx_word, txq[0]);
  endtask

  task automatic model(input logic wr, rd, input logic [1:0] a, input logic [31:0] wd,
                       input logic pop, push, input logic [31:0] pw);
    bit tpush, tpop, rpush, rpop, nov, nun;
    nov   = wr && a == 2'd2 && txq.size() == D;
    nun   = rd && a == 2'd3 && rxq.size() == 0;
    tpush = wr && a == 2'd2 && txq.size() < D;
    tpop  = pop && txq.size() > 0;
    rpush = push && rxq.size() < D;
    rpop  = rd && a == 2'd3 && rxq.size() > 0;
    if (tfl) txq.delete();
    else begin
      if (tpop) void'(txq.pop_front());
      if (tpush) txq.push_back(wd);
    end
    if (rfl) rxq.delete();
    else begin
      if (rpop) void'(rxq.pop_front());
      if (rpush) rxq.push_back(pw);
    end
    tfl = wr && a == 2'd0 && wd[1];
    rfl = wr && a == 2'd0 && wd[0];
    if (wr && a == 2'd0) begin
      ttrig = int'(wd[7:5]);
      rtrig = int'(wd[4:2]);
    end
    eovf = nov;
    eunf = nun;
  endtask

  // called just after a falling edge; returns just after the next one
  task automatic cyc(input logic wr, rd, input logic [1:0] a, input logic [31:0] wd,
                     input logic pop, push, input logic [31:0] pw, input string tag);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
    eng_tx_pop = pop; eng_rx_push = push; eng_rx_word = pw;
    #1;
    compare(a, tag);
    @(posedge clk);
    model(wr, rd, a, wd, pop, push, pw);
    @(negedge clk);
  endtask

  task automatic idle();                     cyc(0, 0, 2'd1, 0, 0, 0, 0, "R5"); endtask
  task automatic wtx(input logic [31:0] d);  cyc(1, 0, 2'd2, d, 0, 0, 0, "R2"); endtask
  task automatic tpop();                     cyc(0, 0, 2'd1, 0, 1, 0, 0, "R3"); endtask
  task automatic rpush(input logic [31:0] d); cyc(0, 0, 2'd1, 0, 0, 1, d, "R4"); endtask
  task automatic rrd();                      cyc(0, 1, 2'd3, 0, 0, 0, 0, "R4"); endtask
  task automatic wctl(input logic [31:0] v); cyc(1, 0, 2'd0, v, 0, 0, 0, "R8"); endtask
  task automatic rctl();                     cyc(0, 0, 2'd0, 0, 0, 0, 0, "R2"); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    eng_tx_pop = 0; eng_rx_push = 0; eng_rx_word = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) idle();

    // R1: reset values
    #1;
    chk("R1", reg_rdata, 32'h80);
    chk("R1", {30'd0, tx_req, rx_req}, 32'h2);
    chk("R1", {30'd0, tx_ovf, rx_unf}, 32'h0);
    @(negedge clk);
    cyc(0, 0, 2'd0, 0, 0, 0, 0, "R1");

    // R3: ordering and pop on empty
    wtx(32'hA000_0001); wtx(32'hA000_0002); wtx(32'hA000_0003);
    cyc(0, 0, 2'd2, 0, 0, 0, 0, "R2");
    tpop(); tpop(); tpop(); tpop(); idle();

    // R6: fill, overflow, write while full with pop
    for (int i = 0; i < D; i++) wtx(32'hB000_0000 + i);
    wtx(32'hDEAD_0001);
    idle();
    cyc(1, 0, 2'd2, 32'hDEAD_0002, 1, 0, 0, "R6");
    idle();
    wtx(32'hB000_0100);
    for (int i = 0; i < D; i++) tpop();

    // R4 / R7: receive fill, drop, drain, underflow
    for (int i = 0; i < D + 1; i++) rpush(32'hC000_0000 + i);
    for (int i = 0; i < D; i++) rrd();
    cyc(0, 1, 2'd3, 0, 0, 0, 0, "R7");
    idle();

    // R5: simultaneous push and pop on each queue
    rpush(32'h1111_0001); rpush(32'h1111_0002);
    cyc(0, 1, 2'd3, 0, 0, 1, 32'h1111_0003, "R5");
    wtx(32'h2222_0001);
    cyc(1, 0, 2'd2, 32'h2222_0002, 1, 0, 0, "R5");
    idle();

    // R9 / R10: trigger thresholds (tx trig 5, rx trig 2)
    wctl(32'hA8);
    rctl();
    wtx(32'h3333_0001); wtx(32'h3333_0002);
    idle();
    rpush(32'h4444_0001);
    idle();

    // R8: flush transmit only, receive untouched
    wctl(32'hAA);
    rctl();
    idle();
    // flush bit 0 written: no effect
    wctl(32'hA8);
    idle();
    // receive flush with a push in the pending cycle
    wctl(32'hA9);
    cyc(0, 0, 2'd0, 0, 0, 1, 32'h5555_0001, "R8");
    idle();
    rctl();

    // R9 / R10 at maximum trigger
    wctl(32'hFC);
    for (int i = 0; i < D; i++) rpush(32'h6666_0000 + i);
    idle();
    for (int i = 0; i < D; i++) wtx(32'h7777_0000 + i);
    wctl(32'hFF);
    idle();
    idle();

    done = 1;
    summary();
    $finish;
  end
endmodule